// File: doc/BRIEF.md
# Indirect Interrupt-Routing Register Window

This block is the software-facing register file of an interrupt router with a table of redirection entries, 24 by default. It has two bus locations. The first is an 8-bit select register. The second is a 32-bit window. The select value chooses what the window reaches:

- the ID register,
- a read-only version word,
- an arbitration word,
- or one half of a 64-bit redirection entry.

Each entry holds these fields:

| Field | Bits |
|---|---|
| vector | [7:0] |
| delivery mode | [10:8] |
| destination mode | [11] |
| delivery status | [12] |
| polarity | [13] |
| remote-IRR | [14] |
| trigger mode | [15], 1 = level |
| mask | [16] |
| destination | [63:56] |

The delivery logic owns the remote-IRR and delivery-status bits. It sets them through a status-update port. A bus write never alters them, with one exception: a write that leaves the entry edge-triggered clears remote-IRR.

Two one-cycle strobes go back to the delivery logic:

- **mask-change:** fires when a write flips an entry's mask bit. It carries the pin and the new mask value.
- **service request:** fires when an entry is written while level-triggered and its pin's registered request bit is set.

Bus reads are combinational. Writes, strobes and the request register all take effect at the clock edge.

Top module: `irq_route_regwin`

## Requirements
- R1: A write to byte offset 0x00 stores bits 7:0 of the write data as the select value. A read at offset 0x00 returns that value in bits 7:0 and zero above.
- R2: With select 0x01, the window reads (NUM_PINS-1) in bits 23:16 and VER_ID in bits 7:0, and zero elsewhere. Window writes with select 0x01 change nothing.
- R3: With select 0x00 or 0x02, the window reads the 4-bit ID in bits 27:24 and zero elsewhere. A window write with select 0x00 loads the ID from write-data bits 27:24. A window write with select 0x02 changes nothing.
- R4: For select values of 0x10 and above, the window reaches entry (select-0x10)>>1 at offset 0x10. An even select reaches entry bits 31:0 and an odd select reaches bits 63:32. A write replaces only that half, except for the bits named in R6 and R7.
- R5: A select value that reaches no entry reads 0xFFFFFFFF through the window, and a window write with it changes nothing. This covers select 0x03 to 0x0F and entry indices of NUM_PINS or more.
- R6: A window write to an entry leaves its delivery-status bit (12) and remote-IRR bit (14) at their previous values.
- R7: After a window write, if the entry's trigger bit (15) is 0, its remote-IRR bit reads 0.
- R8: When a write changes an entry's mask bit (16), mchg_vld is high for exactly the next cycle, with mchg_pin set to the entry index and mchg_mask set to the new mask value. Otherwise mchg_vld is low.
- R9: When a write leaves an entry level-triggered and bit pin of the registered copy of pend_i is set, svc_vld is high for exactly the next cycle, with svc_pin set to the entry index. Otherwise svc_vld is low. pend_i is registered one cycle before use.
- R10: A synchronous reset (rst_n low at a clock edge) sets every entry to 0x0000000000010000 (only the mask bit set). It also clears the select value, the ID, the registered request bits and both strobes.
- R11: Bus reads at any offset other than 0x00 and 0x10 return 0, and writes there change nothing.
- R12: When st_vld is high and st_pin is below NUM_PINS, that entry's remote-IRR bit takes st_rirr and its delivery-status bit takes st_dstat at the edge. These two values win over a bus write to the same entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset (0x00 select, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr and state |
| pend_i | input | NUM_PINS | Per-pin request level from the delivery logic |
| st_vld | input | 1 | Status update valid |
| st_pin | input | IDX_W | Entry index for the status update |
| st_rirr | input | 1 | New remote-IRR value |
| st_dstat | input | 1 | New delivery-status value |
| mchg_vld | output | 1 | Mask-change strobe |
| mchg_pin | output | IDX_W | Entry index whose mask changed |
| mchg_mask | output | 1 | New mask value |
| svc_vld | output | 1 | Level service request strobe |
| svc_pin | output | IDX_W | Entry index to service |

## Verification
Read data is due in the same cycle as the address. Writes, status updates and both strobes are due one edge after the access. The service decision uses the request bits registered at the edge before the write.

The bench drives inputs one time unit after the rising edge. It advances a behavioural model at each rising edge and compares every output at the falling edge. This keeps each comparison inside the cycle where its result is due.

Directed read-backs add named checks for the preserved status bits, the edge-mode clear, the status-update override and the reset contents.

// File: rtl/irw_pkg.sv
// Package: shared entry layout and select/offset codes for the interrupt
// routing register window. Assumes a 64-bit entry split into two 32-bit halves.
package irw_pkg;

    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd;
        logic        mask;
        logic        trig;     // 1 = level
        logic        rirr;
        logic        pol;
        logic        dstat;
        logic        dmode;
        logic [2:0]  dlvmode;
        logic [7:0]  vec;
    } entry_t;

    localparam entry_t ENT_RST   = entry_t'(64'h0000_0000_0001_0000);

    localparam logic [7:0] OFS_SEL = 8'h00;
    localparam logic [7:0] OFS_WIN = 8'h10;

    localparam logic [7:0] SEL_ID  = 8'h00;
    localparam logic [7:0] SEL_VER = 8'h01;
    localparam logic [7:0] SEL_ARB = 8'h02;
    localparam logic [7:0] SEL_ENT = 8'h10;

endpackage

// File: rtl/irw_entry_store.sv
// Entry table: holds NUM_PINS redirection entries, merges 32-bit half writes
// while keeping the status bits, applies status updates from the delivery
// logic and registers the mask-change and service strobes.
// Assumes wr_vld is only raised for an in-range wr_idx.
module irw_entry_store
    import irw_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_vld,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_hi,
    input  logic [31:0]         wr_data,
    input  logic                st_vld,
    input  logic [IDX_W-1:0]    st_idx,
    input  logic                st_rirr,
    input  logic                st_dstat,
    input  logic [NUM_PINS-1:0] pend_q,
    output entry_t              tbl_q [NUM_PINS],
    output logic                mchg_vld,
    output logic [IDX_W-1:0]    mchg_pin,
    output logic                mchg_mask,
    output logic                svc_vld,
    output logic [IDX_W-1:0]    svc_pin
);

    entry_t old_e;
    entry_t mrg_e;

    // Build the merged entry for the half being written.
    always_comb begin
        old_e = tbl_q[wr_idx];
        mrg_e = old_e;
        if (wr_hi) mrg_e[63:32] = wr_data;
        else       mrg_e[31:0]  = wr_data;
        mrg_e.rirr  = old_e.rirr;
        mrg_e.dstat = old_e.dstat;
        if (!mrg_e.trig) mrg_e.rirr = 1'b0;
    end

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_ent
        logic wr_hit;
        logic st_hit;
        assign wr_hit = wr_vld && (wr_idx == IDX_W'(gi));
        assign st_hit = st_vld && (st_idx == IDX_W'(gi));

        // Update one entry: bus merge first, then status override.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl_q[gi] <= ENT_RST;
            end else begin
                if (wr_hit) tbl_q[gi] <= mrg_e;
                if (st_hit) begin
                    tbl_q[gi].rirr  <= st_rirr;
                    tbl_q[gi].dstat <= st_dstat;
                end
            end
        end
    end

    // Register the strobes towards the delivery logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mchg_vld  <= 1'b0;
            mchg_pin  <= '0;
            mchg_mask <= 1'b0;
            svc_vld   <= 1'b0;
            svc_pin   <= '0;
        end else begin
            mchg_vld  <= wr_vld && (mrg_e.mask != old_e.mask);
            mchg_pin  <= wr_idx;
            mchg_mask <= mrg_e.mask;
            svc_vld   <= wr_vld && mrg_e.trig && pend_q[wr_idx];
            svc_pin   <= wr_idx;
        end
    end

    AST_DSTAT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && !(st_vld && st_idx == wr_idx)) |=>
        (tbl_q[$past(wr_idx)].dstat == $past(tbl_q[wr_idx].dstat))); // R6

    AST_EDGE_RIRR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && !(st_vld && st_idx == wr_idx)) |=>
        (tbl_q[$past(wr_idx)].trig || !tbl_q[$past(wr_idx)].rirr)); // R7

    AST_MCHG_FROM_WR: assert property (@(posedge clk) disable iff (!rst_n)
        mchg_vld |-> ($past(wr_vld) && tbl_q[mchg_pin].mask == mchg_mask)); // R8

    AST_SVC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        svc_vld |-> ($past(wr_vld) && tbl_q[svc_pin].trig)); // R9

endmodule

// File: rtl/irw_read_mux.sv
// Read path: selects the bus read word from the select register, the window
// targets (ID, version, arbitration, entry halves) or zero for unused offsets.
// Assumes ent_ok is true only when ent_idx names an existing entry.
module irw_read_mux
    import irw_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter int          IDX_W    = 5,
    parameter logic [7:0]  VER_ID   = 8'h11
) (
    input  logic [7:0]       addr,
    input  logic [7:0]       sel_q,
    input  logic [3:0]       id_q,
    input  logic             ent_ok,
    input  logic [IDX_W-1:0] ent_idx,
    input  entry_t           tbl_q [NUM_PINS],
    output logic [31:0]      rdata
);

    localparam logic [7:0] LAST_PIN = 8'(NUM_PINS - 1);

    logic [31:0] win_word;
    entry_t      rd_e;

    // Decode what the window shows for the current select value.
    always_comb begin
        rd_e = tbl_q[ent_idx];
        if (sel_q == SEL_VER)
            win_word = {8'h00, LAST_PIN, 8'h00, VER_ID};
        else if (sel_q == SEL_ID || sel_q == SEL_ARB)
            win_word = {4'h0, id_q, 24'h0};
        else if (ent_ok)
            win_word = sel_q[0] ? rd_e[63:32] : rd_e[31:0];
        else
            win_word = 32'hFFFF_FFFF;
    end

    // Pick the bus word by offset.
    always_comb begin
        case (addr)
            OFS_SEL: rdata = {24'h0, sel_q};
            OFS_WIN: rdata = win_word;
            default: rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/irq_route_regwin.sv
// Top: indirect select/window register interface of an interrupt router.
// Holds the select register, the ID and the registered request bits, decodes
// bus writes and connects the entry store and the read path.
// Assumes single-cycle 32-bit bus accesses at offsets 0x00 and 0x10.
module irq_route_regwin
    import irw_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter logic [7:0]  VER_ID   = 8'h11,
    localparam int         IDX_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pend_i,
    input  logic                st_vld,
    input  logic [IDX_W-1:0]    st_pin,
    input  logic                st_rirr,
    input  logic                st_dstat,
    output logic                mchg_vld,
    output logic [IDX_W-1:0]    mchg_pin,
    output logic                mchg_mask,
    output logic                svc_vld,
    output logic [IDX_W-1:0]    svc_pin
);

    logic [7:0]          sel_q;
    logic [3:0]          id_q;
    logic [NUM_PINS-1:0] pend_q;
    entry_t              tbl_q [NUM_PINS];

    logic [7:0]  sel_off;
    logic [6:0]  ent_raw;
    logic        ent_ok;
    logic        wr_sel;
    logic        wr_win;
    logic        wr_id;
    logic        st_ok;

    // Entry index derived from the select value.
    always_comb begin
        sel_off = sel_q - SEL_ENT;
        ent_raw = sel_off[7:1];
        ent_ok  = (sel_q >= SEL_ENT) && (ent_raw < 7'(NUM_PINS));
    end

    // Bus write decode.
    always_comb begin
        wr_sel = bus_en && bus_we && (bus_addr == OFS_SEL);
        wr_win = bus_en && bus_we && (bus_addr == OFS_WIN);
        wr_id  = wr_win && (sel_q == SEL_ID);
        st_ok  = st_vld && (st_pin < IDX_W'(NUM_PINS));
    end

    // Select register, ID and request bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            id_q   <= '0;
            pend_q <= '0;
        end else begin
            if (wr_sel) sel_q <= bus_wdata[7:0];
            if (wr_id)  id_q  <= bus_wdata[27:24];
            pend_q <= pend_i;
        end
    end

    irw_entry_store #(
        .NUM_PINS (NUM_PINS),
        .IDX_W    (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_vld    (wr_win && ent_ok),
        .wr_idx    (ent_raw[IDX_W-1:0]),
        .wr_hi     (sel_q[0]),
        .wr_data   (bus_wdata),
        .st_vld    (st_ok),
        .st_idx    (st_pin),
        .st_rirr   (st_rirr),
        .st_dstat  (st_dstat),
        .pend_q    (pend_q),
        .tbl_q     (tbl_q),
        .mchg_vld  (mchg_vld),
        .mchg_pin  (mchg_pin),
        .mchg_mask (mchg_mask),
        .svc_vld   (svc_vld),
        .svc_pin   (svc_pin)
    );

    irw_read_mux #(
        .NUM_PINS (NUM_PINS),
        .IDX_W    (IDX_W),
        .VER_ID   (VER_ID)
    ) u_rd (
        .addr    (bus_addr),
        .sel_q   (sel_q),
        .id_q    (id_q),
        .ent_ok  (ent_ok),
        .ent_idx (ent_raw[IDX_W-1:0]),
        .tbl_q   (tbl_q),
        .rdata   (bus_rdata)
    );

    AST_SEL_RST: assert property (@(posedge clk)
        !rst_n |=> (sel_q == 8'h00 && id_q == 4'h0)); // R10

    AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we && bus_addr == OFS_WIN && sel_q == SEL_ID)
        |=> $stable(id_q)); // R3

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we && bus_addr == OFS_SEL) |=> $stable(sel_q)); // R1

endmodule

// File: tb/tb_irq_route_regwin.sv
module tb_irq_route_regwin;

    localparam int NP = 24;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pend_i = '0;
    logic          st_vld = 1'b0;
    logic [IW-1:0] st_pin = '0;
    logic          st_rirr = 1'b0, st_dstat = 1'b0;
    logic          mchg_vld, mchg_mask, svc_vld;
    logic [IW-1:0] mchg_pin, svc_pin;

    int n_chk = 0;
    int n_fail = 0;
    bit model_ok = 1'b0;
    bit done = 1'b0;

    // model state
    logic [63:0]   m_tbl [NP];
    logic [7:0]    m_sel;
    logic [3:0]    m_id;
    logic [NP-1:0] m_pend;
    bit            e_mchg, e_mval, e_svc;
    int            e_mpin, e_spin;

    always #2 clk = ~clk;   // 250 MHz

    irq_route_regwin dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend_i(pend_i), .st_vld(st_vld), .st_pin(st_pin), .st_rirr(st_rirr),
        .st_dstat(st_dstat), .mchg_vld(mchg_vld), .mchg_pin(mchg_pin),
        .mchg_mask(mchg_mask), .svc_vld(svc_vld), .svc_pin(svc_pin)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_ent_ok(input logic [7:0] s);
        return (s >= 8'h10) && (((int'(s) - 16) >> 1) < NP);
    endfunction

    function automatic logic [31:0] m_rd(input logic [7:0] a);
        logic [63:0] e;
        if (a == 8'h00) return {24'h0, m_sel};
        if (a != 8'h10) return 32'h0;
        if (m_sel == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, 8'h11};
        if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
        if (!m_ent_ok(m_sel)) return 32'hFFFF_FFFF;
        e = m_tbl[(int'(m_sel) - 16) >> 1];
        return m_sel[0] ? e[63:32] : e[31:0];
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        if (a == 8'h00) return "R1";
        if (a != 8'h10) return "R11";
        if (m_sel == 8'h01) return "R2";
        if (m_sel == 8'h00 || m_sel == 8'h02) return "R3";
        if (!m_ent_ok(m_sel)) return "R5";
        return "R4";
    endfunction

    // Reference model: advance on each rising edge.
    always @(posedge clk) begin
        model_ok <= 1'b1;
        if (!rst_n) begin
            m_sel = 8'h00; m_id = 4'h0; m_pend = '0;
            for (int i = 0; i < NP; i++) m_tbl[i] = 64'h0000_0000_0001_0000;
            e_mchg = 0; e_svc = 0; e_mval = 0; e_mpin = 0; e_spin = 0;
        end else begin
            e_mchg = 0; e_svc = 0;
            if (bus_en && bus_we && bus_addr == 8'h00) begin
                m_sel = bus_wdata[7:0];
            end else if (bus_en && bus_we && bus_addr == 8'h10) begin
                if (m_sel == 8'h00) m_id = bus_wdata[27:24];
                else if (m_ent_ok(m_sel)) begin
                    int idx;
                    logic [63:0] o, n;
                    idx = (int'(m_sel) - 16) >> 1;
                    o = m_tbl[idx];
                    n = o;
                    if (m_sel[0]) n[63:32] = bus_wdata; else n[31:0] = bus_wdata;
                    n[12] = o[12]; n[14] = o[14];
                    if (!n[15]) n[14] = 1'b0;
                    if (n[16] != o[16]) begin e_mchg = 1; e_mpin = idx; e_mval = n[16]; end
                    if (n[15] && m_pend[idx]) begin e_svc = 1; e_spin = idx; end
                    m_tbl[idx] = n;
                end
            end
            if (st_vld && int'(st_pin) < NP) begin
                m_tbl[st_pin][14] = st_rirr;
                m_tbl[st_pin][12] = st_dstat;
            end
            m_pend = pend_i;
        end
    end

    // Compare every output at the falling edge.
    always @(negedge clk) begin
        if (model_ok && !done) begin
            chk(rd_tag(bus_addr), 64'(bus_rdata), 64'(m_rd(bus_addr)));
            chk("R8 mchg_vld", 64'(mchg_vld), 64'(e_mchg));
            if (e_mchg) chk("R8 mchg_pin/mask", {mchg_pin, mchg_mask}, {5'(e_mpin), e_mval});
            chk("R9 svc_vld", 64'(svc_vld), 64'(e_svc));
            if (e_svc) chk("R9 svc_pin", 64'(svc_pin), 64'(e_spin));
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 0; bus_we = 0; bus_addr = 8'h00; bus_wdata = 32'h0;
    endtask

    task automatic win_rd(input logic [7:0] s, output logic [31:0] v);
        bus_wr(8'h00, {24'h0, s});
        bus_addr = 8'h10; bus_en = 1;
        @(negedge clk); v = bus_rdata;
        @(posedge clk); #1;
        bus_en = 0; bus_addr = 8'h00;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        // R10: reset contents
        win_rd(8'h10, v); chk("R10 entry0 low", v, 32'h0001_0000);
        win_rd(8'h3F, v); chk("R10 entry23 high", v, 32'h0);
        win_rd(8'h00, v); chk("R10 id", v, 32'h0);
        // R1: select keeps low byte
        bus_wr(8'h00, 32'hABCD_EF5A);
        @(negedge clk); chk("R1 select readback", bus_rdata, 32'h0000_005A);
        // R2: version, write ignored
        win_rd(8'h01, v); chk("R2 version", v, 32'h0017_0011);
        bus_wr(8'h10, 32'hFFFF_FFFF);
        win_rd(8'h01, v); chk("R2 version after write", v, 32'h0017_0011);
        // R3: id write, arb alias, arb write ignored
        bus_wr(8'h00, 32'h0); bus_wr(8'h10, 32'hF5FF_FFFF);
        win_rd(8'h02, v); chk("R3 arb reads id", v, 32'h0500_0000);
        bus_wr(8'h10, 32'h0A00_0000);
        win_rd(8'h00, v); chk("R3 arb write ignored", v, 32'h0500_0000);
        // R4 / R8: unmask pin 0 edge, pin 23 high half
        bus_wr(8'h00, 32'h10); bus_wr(8'h10, 32'h0000_0031);
        bus_wr(8'h00, 32'h3F); bus_wr(8'h10, 32'hAB00_0000);
        win_rd(8'h3E, v); chk("R4 entry23 low untouched", v, 32'h0001_0000);
        win_rd(8'h3F, v); chk("R4 entry23 high", v, 32'hAB00_0000);
        // R5: out of range
        bus_wr(8'h00, 32'h40); bus_wr(8'h10, 32'h0);
        win_rd(8'h40, v); chk("R5 index 24", v, 32'hFFFF_FFFF);
        win_rd(8'h05, v); chk("R5 select 0x05", v, 32'hFFFF_FFFF);
        win_rd(8'hFF, v); chk("R5 select 0xFF", v, 32'hFFFF_FFFF);
        // R11: other offset
        bus_wr(8'h08, 32'h1234_5678);
        bus_addr = 8'h08; @(negedge clk); chk("R11 other offset", bus_rdata, 32'h0);
        @(posedge clk); #1; bus_addr = 8'h00;
        // R9: level write with request pending on pin 7
        pend_i = 24'h00_0080;
        bus_wr(8'h00, 32'h1E); bus_wr(8'h10, 32'h0000_8040);
        bus_wr(8'h10, 32'h0000_8041);
        pend_i = '0;
        bus_wr(8'h10, 32'h0001_8042);
        // R12: status update on pin 3
        @(posedge clk); #1;
        st_vld = 1; st_pin = 5'd3; st_rirr = 1; st_dstat = 1;
        @(posedge clk); #1; st_vld = 0;
        win_rd(8'h16, v); chk("R12 status bits set", 64'(v[14:12]), 64'(3'b101));
        // R6: level write keeps status bits
        bus_wr(8'h10, 32'h0000_8000);
        win_rd(8'h16, v); chk("R6 status kept", 64'(v[15:12]), 64'(4'b1101));
        // R7: edge write clears remote-IRR
        bus_wr(8'h10, 32'h0000_0000);
        win_rd(8'h16, v); chk("R7 rirr cleared", 64'(v[15:12]), 64'(4'b0001));
        // R12: status override against same-cycle write
        bus_wr(8'h00, 32'h18);
        @(posedge clk); #1;
        bus_en = 1; bus_we = 1; bus_addr = 8'h10; bus_wdata = 32'h0000_8000;
        st_vld = 1; st_pin = 5'd4; st_rirr = 1; st_dstat = 0;
        @(posedge clk); #1;
        bus_en = 0; bus_we = 0; bus_addr = 8'h00; st_vld = 0;
        win_rd(8'h18, v); chk("R12 override", 64'(v[15:12]), 64'(4'b1100));
        // R4 / R8 / R9 sweep over all entries
        pend_i = 24'hA5_5A5A;
        for (int k = 0; k < NP; k++) begin
            bus_wr(8'h00, 32'(16 + 2 * k));
            bus_wr(8'h10, {15'h0, (k % 3 == 0), (k % 2 == 1), 7'h0, 8'(k * 7)});
            bus_wr(8'h00, 32'(17 + 2 * k));
            bus_wr(8'h10, {8'(k), 24'h00_0000});
        end
        pend_i = '0;
        for (int k = 0; k < NP; k++) begin
            win_rd(8'(17 + 2 * k), v); chk("R4 sweep high", v, {8'(k), 24'h0});
        end
        // R10: reset again mid-run
        @(posedge clk); #1; rst_n = 0;
        @(posedge clk); #1; rst_n = 1;
        win_rd(8'h20, v); chk("R10 entry8 after reset", v, 32'h0001_0000);
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule